// File: doc/BRIEF.md
# Vectored Interrupt Source Router

This block gathers seven level-style interrupt inputs and forwards each one onto one of eight output interrupt lines. Six routing entries each hold a 16-bit target server number, an 8-bit priority and a 3-bit source-line number. Each entry also keeps a pending flag that records whether its input is currently asserted and not masked. Inputs 0 and 1 share routing entry 0, so they also share the output line that entry selects. Inputs 2 to 6 use entries 1 to 5.

Input changes arrive as single-cycle events: a valid strobe, an input index and the new level. Routing entries are written 64 bits at a time through a simple write port and can be read back through a registered read port. A priority of all ones masks an entry. A masked entry still drives its line and records status, but its pending flag never sets. Out-of-range accesses are dropped and reported on a one-cycle error strobe.

Top module: `vsr_router`

## Requirements
- R1: After synchronous reset, entry i reads back with server 0, priority 0xFF, source i and pending 0. All status bits and all output lines are 0.
- R2: The 64-bit routing word holds the server number in bits 55:40, the priority in bits 39:32, the source-line number in bits 31:29 and the pending flag in bit 24. All other bits read 0. A write to entry `wr_sel` stores the server, priority and source fields. A read returns the entry selected by `rd_sel` one cycle later.
- R3: A write leaves the pending flag unchanged when the new priority is not 0xFF. It clears the pending flag when the new priority is 0xFF.
- R4: An assert event (level 1) for input k sets status bit k (`stat_o[k]`). It raises output line L, where L is the source field of the input's entry. Input 0 or 1 maps to entry 0, and input k of 2 or more maps to entry k-1. The entry's pending flag is set if the priority is not 0xFF.
- R5: A deassert event for input k of 2 or more clears status bit k, lowers line L and clears the entry's pending flag.
- R6: A deassert event for input 0 or 1 clears its own status bit and the pending flag of entry 0. Line L is lowered only if the status bit of the other shared input is also clear.
- R7: When an entry's priority is 0xFF, assert events still set the status bit and raise the line, but the pending flag stays 0.
- R8: An event with input index 7 changes no status bit, no line and no pending flag. It pulses `err_o` high for the cycle after the event.
- R9: A write whose source field is 6 or 7 is stored and pulses `err_o`. A write with `wr_sel` of 6 or 7 changes no entry and pulses `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Routing entry write strobe |
| wr_sel | input | 3 | Entry to write |
| wr_data | input | 64 | Routing word to write |
| rd_sel | input | 3 | Entry to read |
| rd_data | output | 64 | Registered routing word of the selected entry |
| evt_valid | input | 1 | Input change event strobe |
| evt_idx | input | 3 | Index of the changing input |
| evt_level | input | 1 | New level of that input |
| stat_o | output | 7 | Status bit per input; bit k belongs to input k |
| irq_line_o | output | 8 | Output interrupt lines |
| err_o | output | 1 | One-cycle error strobe |

## Verification
The bench sweeps every input against every line number, both masked and unmasked. A router that used the wrong entry for an input, or decoded the source field from the wrong bits, would raise the wrong line. The shared pair is driven in both release orders. A design that lowered the shared line on the first release would drop an interrupt that is still active. Pending retention is checked across rewrites and masking: a design that reloaded the flag from write data would lose a live pending, and one that ignored a write of priority 0xFF would report a masked source as pending. Out-of-range indices and selectors are checked so that they leave every observable bit untouched while still pulsing the error strobe.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  localparam int REG_W   = 64;
  localparam int SRV_LO  = 40;
  localparam int SRV_W   = 16;
  localparam int PRI_LO  = 32;
  localparam int PRI_W   = 8;
  localparam int SRC_LO  = 29;
  localparam int SRC_W   = 3;
  localparam int PEND_B  = 24;

  typedef struct packed {
    logic [SRV_W-1:0] server;
    logic [PRI_W-1:0] prio;
    logic [SRC_W-1:0] src;
    logic             pend;
  } route_t;

  function automatic logic [REG_W-1:0] route_pack(route_t r);
    logic [REG_W-1:0] v;
    v = '0;
    v[SRV_LO +: SRV_W] = r.server;
    v[PRI_LO +: PRI_W] = r.prio;
    v[SRC_LO +: SRC_W] = r.src;
    v[PEND_B]          = r.pend;
    return v;
  endfunction
endpackage

// File: rtl/vsr_route_file.sv
module vsr_route_file
  import vsr_pkg::*;
#(
  parameter int NUM_ENTRIES = 6,
  parameter int SEL_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [REG_W-1:0] rd_data,
  input  logic             ev_en,
  input  logic [SEL_W-1:0] ev_entry,
  input  logic             ev_level,
  output logic [SRC_W-1:0] ev_src,
  output logic             wr_err
);
  localparam logic [PRI_W-1:0] MASK_PRI = '1;

  route_t ent [NUM_ENTRIES];
  route_t nxt [NUM_ENTRIES];

  logic             wr_ok;
  logic [PRI_W-1:0] new_pri;
  logic [SRC_W-1:0] new_src;
  logic             unused_bits;

  assign new_pri = wr_data[PRI_LO +: PRI_W];
  assign new_src = wr_data[SRC_LO +: SRC_W];
  assign wr_ok   = wr_en && (int'(wr_sel) < NUM_ENTRIES);
  assign unused_bits = ^{wr_data[REG_W-1:SRV_LO+SRV_W], wr_data[SRC_LO-1:0]};

  assign ev_src = (int'(ev_entry) < NUM_ENTRIES) ? ent[ev_entry].src : '0;

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      nxt[i] = ent[i];
      if (ev_en && int'(ev_entry) == i)
        nxt[i].pend = ev_level && (ent[i].prio != MASK_PRI);
      if (wr_ok && int'(wr_sel) == i) begin
        nxt[i].server = wr_data[SRV_LO +: SRV_W];
        nxt[i].prio   = new_pri;
        nxt[i].src    = new_src;
        if (new_pri == MASK_PRI) nxt[i].pend = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        ent[i] <= '{server: '0, prio: MASK_PRI, src: SRC_W'(i), pend: 1'b0};
      end
      rd_data <= '0;
      wr_err  <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) ent[i] <= nxt[i];
      rd_data <= (int'(rd_sel) < NUM_ENTRIES) ? route_pack(ent[rd_sel]) : '0;
      wr_err  <= wr_en && (!wr_ok || int'(new_src) >= NUM_ENTRIES);
    end
  end

  generate
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_chk
      // R7
      masked_no_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (ent[g].prio == MASK_PRI) |-> !ent[g].pend);
      // R3
      pend_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && int'(wr_sel) == g && new_pri != MASK_PRI &&
         !(ev_en && int'(ev_entry) == g)) |=> (ent[g].pend == $past(ent[g].pend)));
    end
  endgenerate

  // R9
  wr_err_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_sel) >= NUM_ENTRIES) |=> wr_err);
endmodule

// File: rtl/vsr_status.sv
module vsr_status
  import vsr_pkg::*;
#(
  parameter int NUM_INPUTS = 7,
  parameter int NUM_LINES  = 8,
  parameter int IDX_W      = 3,
  parameter int SEL_W      = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  evt_valid,
  input  logic [IDX_W-1:0]      evt_idx,
  input  logic                  evt_level,
  input  logic [SRC_W-1:0]      ev_src,
  output logic                  ev_en,
  output logic [SEL_W-1:0]      ev_entry,
  output logic [NUM_INPUTS-1:0] stat_o,
  output logic [NUM_LINES-1:0]  line_o,
  output logic                  idx_err
);
  logic is_shared;
  logic partner_on;

  assign ev_en      = evt_valid && (int'(evt_idx) < NUM_INPUTS);
  assign is_shared  = (int'(evt_idx) < 2);
  assign ev_entry   = is_shared ? '0 : SEL_W'(int'(evt_idx) - 1);
  assign partner_on = is_shared && stat_o[{{(IDX_W-1){1'b0}}, ~evt_idx[0]}];

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_o  <= '0;
      line_o  <= '0;
      idx_err <= 1'b0;
    end else begin
      idx_err <= evt_valid && !ev_en;
      if (ev_en) begin
        stat_o[evt_idx] <= evt_level;
        if (evt_level) line_o[ev_src] <= 1'b1;
        else if (!partner_on) line_o[ev_src] <= 1'b0;
      end
    end
  end

  // R8
  idx_err_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && int'(evt_idx) >= NUM_INPUTS) |=>
      (idx_err && stat_o == $past(stat_o) && line_o == $past(line_o)));
  // R6
  shared_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && int'(evt_idx) < 2 && !evt_level &&
     stat_o[{{(IDX_W-1){1'b0}}, ~evt_idx[0]}]) |=> (line_o == $past(line_o)));
  // R4
  raise_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_en && evt_level) |=> (line_o[$past(ev_src)] && stat_o[$past(evt_idx)]));
endmodule

// File: rtl/vsr_router.sv
module vsr_router
  import vsr_pkg::*;
#(
  parameter int NUM_ENTRIES = 6
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  wr_en,
  input  logic [$clog2(NUM_ENTRIES+1)-1:0]      wr_sel,
  input  logic [REG_W-1:0]                      wr_data,
  input  logic [$clog2(NUM_ENTRIES+1)-1:0]      rd_sel,
  output logic [REG_W-1:0]                      rd_data,
  input  logic                                  evt_valid,
  input  logic [$clog2(NUM_ENTRIES+2)-1:0]      evt_idx,
  input  logic                                  evt_level,
  output logic [NUM_ENTRIES:0]                  stat_o,
  output logic [(2**SRC_W)-1:0]                 irq_line_o,
  output logic                                  err_o
);
  localparam int NUM_INPUTS = NUM_ENTRIES + 1;
  localparam int NUM_LINES  = 2 ** SRC_W;
  localparam int SEL_W      = $clog2(NUM_ENTRIES + 1);
  localparam int IDX_W      = $clog2(NUM_ENTRIES + 2);

  logic             ev_en;
  logic [SEL_W-1:0] ev_entry;
  logic [SRC_W-1:0] ev_src;
  logic             wr_err;
  logic             idx_err;

  vsr_route_file #(.NUM_ENTRIES(NUM_ENTRIES), .SEL_W(SEL_W)) route_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .ev_en(ev_en), .ev_entry(ev_entry), .ev_level(evt_level),
    .ev_src(ev_src), .wr_err(wr_err)
  );

  vsr_status #(.NUM_INPUTS(NUM_INPUTS), .NUM_LINES(NUM_LINES),
               .IDX_W(IDX_W), .SEL_W(SEL_W)) stat_i (
    .clk(clk), .rst(rst),
    .evt_valid(evt_valid), .evt_idx(evt_idx), .evt_level(evt_level),
    .ev_src(ev_src), .ev_en(ev_en), .ev_entry(ev_entry),
    .stat_o(stat_o), .line_o(irq_line_o), .idx_err(idx_err)
  );

  assign err_o = wr_err | idx_err;
endmodule

// File: tb/vsr_router_tb_top.sv
module vsr_router_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [63:0] rd_data;
  logic        evt_valid = 1'b0;
  logic [2:0]  evt_idx = '0;
  logic        evt_level = 1'b0;
  logic [6:0]  stat_o;
  logic [7:0]  irq_line_o;
  logic        err_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vsr_router dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .evt_valid(evt_valid),
    .evt_idx(evt_idx), .evt_level(evt_level), .stat_o(stat_o),
    .irq_line_o(irq_line_o), .err_o(err_o)
  );

  function automatic logic [63:0] word(int srv, int pri, int src, int pend);
    return (64'(srv & 16'hFFFF) << 40) | (64'(pri & 8'hFF) << 32) |
           (64'(src & 7) << 29) | (64'(pend & 1) << 24);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(int sel, logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_evt(int idx, logic lvl);
    @(negedge clk);
    evt_valid = 1'b1; evt_idx = 3'(idx); evt_level = lvl;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic do_rd(int sel, output logic [63:0] v);
    @(negedge clk);
    rd_sel = 3'(sel);
    @(negedge clk);
    v = rd_data;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 status", 64'(stat_o), 64'd0);
    chk("R1 lines", 64'(irq_line_o), 64'd0);
    for (int e = 0; e < 6; e++) begin
      do_rd(e, v);
      chk("R1 entry", v, word(0, 255, e, 0));
    end

    // R2 R4 R5 R7 sweep: every input x every line x masked/unmasked
    for (int inp = 0; inp < 7; inp++) begin
      for (int s = 0; s < 8; s++) begin
        for (int m = 0; m < 2; m++) begin
          int ent;
          int pri;
          int srv;
          ent = (inp < 2) ? 0 : inp - 1;
          pri = (m == 1) ? 255 : ((inp * 8 + s) & 127);
          srv = inp * 4099 + s * 37 + m;
          do_wr(ent, word(srv, pri, s, 0) | 64'hFF00_0000_1EFF_FFFF);
          chk("R9 src error", 64'(err_o), 64'(s >= 6));
          do_evt(inp, 1'b1);
          chk("R4 status", 64'(stat_o), 64'(1) << inp);
          chk("R4 line", 64'(irq_line_o), 64'(1) << s);
          chk("R4 no err", 64'(err_o), 64'd0);
          do_rd(ent, v);
          if (m == 1) chk("R7 masked pend", v, word(srv, pri, s, 0));
          else        chk("R2 R4 word", v, word(srv, pri, s, 1));
          do_evt(inp, 1'b0);
          chk("R5 status", 64'(stat_o), 64'd0);
          chk("R5 line", 64'(irq_line_o), 64'd0);
          do_rd(ent, v);
          chk("R5 pend clr", v, word(srv, pri, s, 0));
        end
      end
    end

    // R6 shared pair, both release orders
    do_wr(0, word(11, 5, 3, 0));
    for (int ord = 0; ord < 2; ord++) begin
      do_evt(0, 1'b1);
      do_evt(1, 1'b1);
      chk("R6 both up", 64'(irq_line_o), 64'h08);
      chk("R6 both stat", 64'(stat_o), 64'h03);
      do_evt(ord, 1'b0);
      chk("R6 hold line", 64'(irq_line_o), 64'h08);
      chk("R6 one stat", 64'(stat_o), 64'(1) << (1 - ord));
      do_rd(0, v);
      chk("R6 pend clr", v, word(11, 5, 3, 0));
      do_evt(1 - ord, 1'b0);
      chk("R6 line low", 64'(irq_line_o), 64'h00);
      chk("R6 stat low", 64'(stat_o), 64'h00);
    end

    // R3 pending kept across rewrite, cleared by mask write
    do_wr(2, word(7, 4, 5, 0));
    do_evt(3, 1'b1);
    do_wr(2, word(900, 9, 5, 0));
    do_rd(2, v);
    chk("R3 pend kept", v, word(900, 9, 5, 1));
    do_wr(2, word(901, 255, 5, 1));
    do_rd(2, v);
    chk("R3 pend cleared", v, word(901, 255, 5, 0));
    chk("R3 line stays", 64'(irq_line_o), 64'h20);
    do_evt(3, 1'b0);
    chk("R3 line low", 64'(irq_line_o), 64'h00);

    // R8 out-of-range input index
    do_wr(4, word(1, 2, 1, 0));
    do_evt(5, 1'b1);
    do_evt(7, 1'b0);
    chk("R8 err", 64'(err_o), 64'd1);
    chk("R8 stat kept", 64'(stat_o), 64'h20);
    chk("R8 line kept", 64'(irq_line_o), 64'h02);
    do_evt(7, 1'b1);
    chk("R8 err2", 64'(err_o), 64'd1);
    chk("R8 line kept2", 64'(irq_line_o), 64'h02);
    do_rd(4, v);
    chk("R8 pend kept", v, word(1, 2, 1, 1));
    do_evt(5, 1'b0);

    // R9 write to out-of-range entry
    for (int e = 0; e < 6; e++) do_wr(e, word(e + 100, e + 1, e, 0));
    do_wr(6, word(5555, 3, 2, 0));
    chk("R9 sel6 err", 64'(err_o), 64'd1);
    do_wr(7, word(6666, 3, 2, 0));
    chk("R9 sel7 err", 64'(err_o), 64'd1);
    for (int e = 0; e < 6; e++) begin
      do_rd(e, v);
      chk("R9 entry kept", v, word(e + 100, e + 1, e, 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule